// File: doc/BRIEF.md
# Cascaded Averaging Bartlett Filter

This block low-pass filters a stream of 14-bit two's-complement sensor samples. Two identical moving-average stages are connected in series. Each stage averages the last N samples it has accepted, so the combined impulse response is a triangle (Bartlett window) that spans 2N-1 input samples. Both stages share one tap setting, N = 2^M, where M comes from a 3-bit field. Each stage keeps a running sum over a circular history buffer and divides by an arithmetic right shift of M bits.

A range code selects the measurement sensitivity. Each range also sets a minimum filter length. If the programmed M is below the minimum for the selected range, the block raises it to that minimum. Whenever the tap field or the range code changes, both stages discard their history. The output valid strobe then stays low until the second stage again holds a full window. Samples arrive with a valid strobe and may have gaps of any length between them. Each filtered result leaves with its own one-cycle valid strobe.

Top module: `bartlett_filter`

## Requirements
- R1: Each stage averages its last N = 2^M accepted inputs, and the second stage averages the first stage's results, so every output is the average of N consecutive first-stage averages.
- R2: Each stage divides its sum by an arithmetic right shift of M bits, which rounds toward negative infinity. For example, a window holding -1 and 0 with M = 1 gives -1.
- R3: Range code 3'b100 imposes no minimum on M. The unassigned codes 3'b000, 3'b011, 3'b101, 3'b110 and 3'b111 behave the same way.
- R4: Range code 3'b010 raises any M below 2 to an effective M of 2, so each stage has at least 4 taps.
- R5: Range code 3'b001 raises any M below 4 to an effective M of 4, so each stage has at least 16 taps.
- R6: An effective M of 0 passes each input sample through unchanged.
- R7: A sample accepted at a rising edge produces its result on the output pins after the next rising edge. out_valid is high for exactly one cycle per result.
- R8: After a clear, out_valid stays low until 2N-1 samples have been accepted. The 2N-1th sample produces the first result.
- R9: A change of tap_sel or range_sel, seen at a rising edge, clears both stages. A sample presented at that same edge is discarded. out_valid is low after that edge.
- R10: While rst_n is low, out_valid and out_data are zero.
- R11: Cycles with in_valid low change neither the stage state nor the output. No result appears for them.
- R12: The configuration present at the first rising edge after reset is adopted without a clear. A sample at that edge is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | High when in_data carries a sample to accept |
| in_data | input | 14 | Input sample, two's complement |
| tap_sel | input | 3 | Programmed M; each stage has 2^M taps |
| range_sel | input | 3 | Range code: 100 wide, 010 mid (M of at least 2), 001 narrow (M of at least 4) |
| out_valid | output | 1 | One-cycle strobe marking a filtered result |
| out_data | output | 14 | Filtered sample, two's complement |

## Verification
Each stage registers its result, so a sample accepted at one rising edge reaches the output pins after the following edge. A configuration change takes effect at the edge where it is first seen. The bench evaluates its model at every rising edge, in the same order as the hardware: the first-stage value held from the previous edge feeds the second stage before the current input is taken. The model compares out_valid at every falling edge, and out_data whenever a result is due. Because of this, any error in latency, in the fill point of 2N-1 samples, or in a clear shows up as a mismatch at a specific cycle.

// File: rtl/bartlett_pkg.sv
package bartlett_pkg;
   // Number of cascaded averaging stages (the triangle needs exactly two)
   localparam int unsigned STAGE_COUNT = 2;

   // Range codes: the sensitivity selection that also sets the minimum length
   localparam logic [2:0] RNG_WIDE   = 3'b100;
   localparam logic [2:0] RNG_MID    = 3'b010;
   localparam logic [2:0] RNG_NARROW = 3'b001;

   // Minimum log2 tap count that each range imposes
   localparam int unsigned MID_MIN_M    = 2;
   localparam int unsigned NARROW_MIN_M = 4;
endpackage

// File: rtl/tap_policy.sv
module tap_policy
   import bartlett_pkg::*;
#(
   parameter int M_W = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [M_W-1:0] tap_sel,
   input  logic [2:0]     range_sel,
   output logic [M_W-1:0] m_eff,
   output logic           clr
);
   localparam int CFG_W = M_W + 3;

   logic [CFG_W-1:0] cfg_q;
   logic             seen_q;
   logic [M_W-1:0]   floor_m;

   // Minimum M for the selected range; unassigned codes impose none
   always_comb begin
      if (range_sel == RNG_NARROW)
         floor_m = M_W'(NARROW_MIN_M);
      else if (range_sel == RNG_MID)
         floor_m = M_W'(MID_MIN_M);
      else
         floor_m = '0;
      m_eff = (tap_sel < floor_m) ? floor_m : tap_sel;
   end

   // The first edge after reset adopts the configuration without a clear
   assign clr = seen_q && (cfg_q != {tap_sel, range_sel});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         seen_q <= 1'b0;
      end else begin
         cfg_q  <= {tap_sel, range_sel};
         seen_q <= 1'b1;
      end
   end

   // R9
   // cfg_track_chk
   cfg_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cfg_q == $past({tap_sel, range_sel})));
endmodule

// File: rtl/boxcar_stage.sv
module boxcar_stage #(
   parameter int DATA_W = 14,
   parameter int M_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic [M_W-1:0]    m,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);
   localparam int MAX_M = (1 << M_W) - 1;
   localparam int DEPTH = 1 << MAX_M;
   localparam int PTR_W = MAX_M;
   localparam int CNT_W = MAX_M + 1;
   localparam int SUM_W = DATA_W + MAX_M;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("boxcar_stage: DATA_W must be at least 2");
      end
      if (M_W < 1) begin : g_bad_mw
         $error("boxcar_stage: M_W must be at least 1");
      end
   endgenerate

   logic [DATA_W-1:0]       hist [DEPTH];
   logic [PTR_W-1:0]        wr_ptr;
   logic [PTR_W-1:0]        rd_ptr;
   logic [CNT_W-1:0]        fill;
   logic [CNT_W-1:0]        n_taps;
   logic                    full;
   logic                    fills_now;
   logic [DATA_W-1:0]       oldest;
   logic signed [SUM_W-1:0] acc;
   logic signed [SUM_W-1:0] acc_nx;
   logic signed [SUM_W-1:0] in_ext;
   logic signed [SUM_W-1:0] old_ext;
   logic signed [SUM_W-1:0] scaled;

   assign n_taps    = CNT_W'(1) << m;
   assign full      = (fill == n_taps);
   assign fills_now = full || ((fill + CNT_W'(1)) == n_taps);
   // Slot written N accepts ago; when N equals the depth it is the slot about to be overwritten
   assign rd_ptr    = wr_ptr - n_taps[PTR_W-1:0];
   assign oldest    = full ? hist[rd_ptr] : '0;
   assign in_ext    = SUM_W'($signed(in_data));
   assign old_ext   = SUM_W'($signed(oldest));
   assign acc_nx    = acc + in_ext - old_ext;
   assign scaled    = acc_nx >>> m;

   // History storage holds no reset; the fill count masks stale entries
   always_ff @(posedge clk) begin
      if (in_valid && !clr)
         hist[wr_ptr] <= in_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr    <= '0;
         fill      <= '0;
         acc       <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
      end else if (clr) begin
         wr_ptr    <= '0;
         fill      <= '0;
         acc       <= '0;
         out_valid <= 1'b0;
      end else if (in_valid) begin
         wr_ptr    <= wr_ptr + PTR_W'(1);
         fill      <= full ? fill : fill + CNT_W'(1);
         acc       <= acc_nx;
         out_valid <= fills_now;
         if (fills_now)
            out_data <= scaled[DATA_W-1:0];
      end else begin
         out_valid <= 1'b0;
      end
   end

   // R11
   // idle_hold_chk
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && !clr) |=> $stable(acc) && $stable(wr_ptr));

   // R8
   // window_full_chk
   window_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !clr) |-> full);
endmodule

// File: rtl/bartlett_filter.sv
module bartlett_filter
   import bartlett_pkg::*;
#(
   parameter int DATA_W = 14,
   parameter int M_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic [M_W-1:0]    tap_sel,
   input  logic [2:0]        range_sel,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);
   localparam int MAX_M = (1 << M_W) - 1;

   generate
      if (MAX_M < NARROW_MIN_M) begin : g_bad_m
         $error("bartlett_filter: M_W too small for the narrow range minimum");
      end
      if (STAGE_COUNT != 2) begin : g_bad_stages
         $error("bartlett_filter: the triangular response needs two stages");
      end
   endgenerate

   logic [M_W-1:0]    m_eff;
   logic              clr;
   logic              s_valid [STAGE_COUNT+1];
   logic [DATA_W-1:0] s_data  [STAGE_COUNT+1];

   tap_policy #(.M_W(M_W)) u_policy (
      .clk       (clk),
      .rst_n     (rst_n),
      .tap_sel   (tap_sel),
      .range_sel (range_sel),
      .m_eff     (m_eff),
      .clr       (clr)
   );

   assign s_valid[0] = in_valid;
   assign s_data[0]  = in_data;

   generate
      for (genvar g = 0; g < STAGE_COUNT; g++) begin : g_stage
         boxcar_stage #(.DATA_W(DATA_W), .M_W(M_W)) u_avg (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (clr),
            .m         (m_eff),
            .in_valid  (s_valid[g]),
            .in_data   (s_data[g]),
            .out_valid (s_valid[g+1]),
            .out_data  (s_data[g+1])
         );
      end
   endgenerate

   assign out_valid = s_valid[STAGE_COUNT];
   assign out_data  = s_data[STAGE_COUNT];

   // R9
   // cfg_clear_chk
   cfg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !out_valid);

   // R7
   // pipe_order_chk
   pipe_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(s_valid[1]));

   // R6
   // pass_through_chk
   pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid[1] && !clr && m_eff == '0) |=> out_valid && (out_data == $past(s_data[1])));
endmodule

// File: tb/bartlett_filter_test.sv
`timescale 1ns/1ps
module bartlett_filter_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [13:0] in_data = '0;
   logic [2:0]  tap_sel = 3'd0;
   logic [2:0]  range_sel = 3'b100;
   logic        out_valid;
   logic [13:0] out_data;

   int    n_checks = 0;
   int    n_fails = 0;
   bit    checking = 1'b0;
   bit    finished = 1'b0;
   string cur_req = "R10";

   always #4 clk = ~clk;

   bartlett_filter uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .tap_sel(tap_sel), .range_sel(range_sel),
      .out_valid(out_valid), .out_data(out_data)
   );

   // Effective M from the range rules (R3, R4, R5)
   function automatic int eff_m(input int tap, input logic [2:0] rng);
      int lo;
      lo = (rng == 3'b001) ? 4 : (rng == 3'b010) ? 2 : 0;
      return (tap < lo) ? lo : tap;
   endfunction

   // Floor average of a full window (R1, R2)
   function automatic int qavg(input int q[$], input int m);
      int s = 0;
      foreach (q[i]) s += q[i];
      return s >>> m;
   endfunction

   // Reference model, evaluated at every rising edge
   int   xq[$];
   int   s1q[$];
   bit   m_seen = 1'b0;
   logic [5:0] m_cfg = '0;
   bit   e1_v = 1'b0;
   int   e1_d = 0;
   bit   exp_v = 1'b0;
   int   exp_d = 0;

   always @(posedge clk) begin
      int m;
      int n;
      if (!rst_n) begin
         xq.delete(); s1q.delete();
         m_seen = 1'b0; e1_v = 1'b0; exp_v = 1'b0; exp_d = 0;
      end else if (m_seen && ({tap_sel, range_sel} != m_cfg)) begin
         // R9: clear, sample at this edge dropped
         xq.delete(); s1q.delete();
         e1_v = 1'b0; exp_v = 1'b0;
         m_cfg = {tap_sel, range_sel};
      end else begin
         m_seen = 1'b1;
         m_cfg = {tap_sel, range_sel};
         m = eff_m(int'(tap_sel), range_sel);
         n = 1 << m;
         exp_v = 1'b0;
         if (e1_v) begin
            s1q.push_back(e1_d);
            while (s1q.size() > n) void'(s1q.pop_front());
            if (s1q.size() == n) begin
               exp_v = 1'b1;
               exp_d = qavg(s1q, m);
            end
         end
         e1_v = 1'b0;
         if (in_valid) begin
            xq.push_back(int'($signed(in_data)));
            while (xq.size() > n) void'(xq.pop_front());
            if (xq.size() == n) begin
               e1_v = 1'b1;
               e1_d = qavg(xq, m);
            end
         end
      end
   end

   // Output comparison away from the active edge (R7, R8 and all data checks)
   always @(negedge clk) begin
      if (checking && !finished) begin
         n_checks++;
         if (out_valid !== exp_v) begin
            n_fails++;
            $display("FAIL %s: out_valid=%0b expected %0b", cur_req, out_valid, exp_v);
         end else if (exp_v) begin
            n_checks++;
            if (out_data !== 14'(exp_d)) begin
               n_fails++;
               $display("FAIL %s: out_data=%0d expected %0d", cur_req,
                        $signed(out_data), exp_d);
            end
         end
      end
   end

   task automatic drive(input bit v, input int d);
      @(negedge clk);
      in_valid = v;
      in_data  = 14'(d);
   endtask

   task automatic set_cfg(input int t, input logic [2:0] r, input bit v, input int d);
      @(negedge clk);
      tap_sel = 3'(t); range_sel = r; in_valid = v; in_data = 14'(d);
   endtask

   task automatic burst(input int count, input int pct);
      for (int i = 0; i < count; i++) begin
         bit v;
         v = ($urandom % 100) < pct;
         drive(v, int'($urandom & 32'h3FFF));
      end
      drive(0, 0);
      drive(0, 0);
   endtask

   task automatic summary();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         n_fails++;
         $display("FAIL watchdog: run expired, expected completion");
         summary();
      end
   end

   initial begin
      void'($urandom(32'h5EED));
      tap_sel = 3'd1; range_sel = 3'b100;
      repeat (3) @(negedge clk);
      // R10: reset state
      n_checks++;
      if (out_valid !== 1'b0 || out_data !== 14'd0) begin
         n_fails++;
         $display("FAIL R10: out_valid=%0b out_data=%0d expected 0 0", out_valid, out_data);
      end
      rst_n = 1'b1;
      in_valid = 1'b1; in_data = 14'd100;
      checking = 1'b1;
      // R12: first configuration adopted, first sample kept
      cur_req = "R12";
      drive(1, 200); drive(1, 300); drive(1, 400);
      burst(20, 100);

      // R6: pass-through with gaps and extremes
      cur_req = "R6";
      set_cfg(0, 3'b100, 0, 0);
      drive(1, 14'h1FFF); drive(1, 14'h2000); drive(0, 0); drive(1, 14'h3FFF);
      burst(40, 60);

      // R2: floor rounding on alternating -1/0 with M = 1
      cur_req = "R2";
      set_cfg(1, 3'b100, 0, 0);
      for (int i = 0; i < 12; i++) drive(1, (i % 2 == 0) ? 14'h3FFF : 0);
      drive(0, 0); drive(0, 0);

      // R1: random data, M = 2 and M = 3
      cur_req = "R1";
      set_cfg(2, 3'b100, 0, 0);
      burst(60, 80);
      set_cfg(3, 3'b000, 0, 0);
      cur_req = "R3";
      burst(60, 70);

      // R4: mid range raises M = 0 to 2
      cur_req = "R4";
      set_cfg(0, 3'b010, 0, 0);
      burst(40, 100);

      // R5: narrow range raises M = 1 to 4 (first result on sample 31)
      cur_req = "R5";
      set_cfg(1, 3'b001, 0, 0);
      burst(70, 100);

      // R9: change with a sample on the change edge, mid stream
      cur_req = "R9";
      set_cfg(2, 3'b100, 1, 50);
      burst(20, 100);
      set_cfg(2, 3'b111, 1, 77);
      burst(20, 100);

      // R11: long idle gaps
      cur_req = "R11";
      set_cfg(1, 3'b010, 0, 0);
      burst(80, 15);

      // R8: widest window, constant extremes then random (first result on sample 255)
      cur_req = "R8";
      set_cfg(7, 3'b100, 0, 0);
      for (int i = 0; i < 260; i++) drive(1, 14'h1FFF);
      for (int i = 0; i < 260; i++) drive(1, 14'h2000);
      burst(300, 90);

      repeat (4) @(negedge clk);
      summary();
   end
endmodule